// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of a network interface, between the line-side byte stream and the packet memory. Each arriving frame is a run of bytes marked by a start flag on its first byte and an end flag on its last. The block collects the first six bytes as the 48-bit destination address. It then decides whether the station wants the frame.

A frame is kept when its destination is the station's own unicast address, the all-ones broadcast address, or a valid entry of a small programmable multicast table. A promiscuous control bit accepts every complete frame. Kept frames leave the block byte for byte, header included, with their start and end flags intact. Dropped frames leave no trace on the output.

The block holds bytes in a small queue until the verdict for their frame is known. It reports each verdict on a one-cycle decision strobe. A plain register write port sets up the unicast address, the control bit and the multicast table.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset no output beat and no decision strobe appear until a frame arrives; promiscuous mode is off and every multicast entry is invalid.
- R2: The destination is the first six bytes of a frame, most significant byte first; a frame whose destination equals the programmed unicast address is accepted.
- R3: A frame whose destination is all ones (FF:FF:FF:FF:FF:FF) is accepted.
- R4: A frame whose destination equals the address of a multicast entry with its valid bit set is accepted; an entry whose valid bit is clear never matches, whatever address it holds.
- R5: With every multicast entry invalid (empty list), only unicast and broadcast destinations are accepted.
- R6: A frame of six or more bytes that matches none of the accepted sources, with promiscuous mode off, is dropped: dec_accept is 0 and no output beat of it appears.
- R7: dec_valid is high for exactly one cycle per frame. For a frame of six or more bytes this is the cycle after the sixth byte is taken, and dec_accept carries the verdict in that same cycle.
- R8: With the promiscuous bit set, every frame of six or more bytes is accepted.
- R9: A frame of fewer than six bytes is dropped even in promiscuous mode. Its decision strobe, with dec_accept 0, comes in the cycle after its end byte.
- R10: An accepted frame is output in full, every byte in arrival order, with out_sof on its first byte and out_eof on its last; frames leave in arrival order.
- R11: Write port map: address 0 loads the unicast address from cfg_wdata[47:0]; address 1 loads the promiscuous bit from cfg_wdata[0]; address 2+i loads multicast entry i, with its address from cfg_wdata[47:0] and its valid bit from cfg_wdata[48]; writes to any other address change nothing.
- R12: Bytes presented with in_valid high outside a frame (no start flag, no frame open) are ignored and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | $clog2(N_MC+2) | Register write address |
| cfg_wdata | input | 49 | Register write data (bit 48 is the entry valid bit) |
| in_valid | input | 1 | Input byte present |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte present |
| out_sof | output | 1 | Output byte is the first of a frame |
| out_eof | output | 1 | Output byte is the last of a frame |
| out_data | output | 8 | Output byte |
| dec_valid | output | 1 | Verdict strobe, one cycle per frame |
| dec_accept | output | 1 | Verdict: 1 keep, 0 drop |

## Verification
The bench builds the filter with three multicast entries, so the write port has unused addresses 5 to 7 that make the ignored-write rule observable. A table of that size is also small enough that each entry can be set, cleared and left empty within a short run. The default queue depths of 16 data beats and 8 verdicts are kept. Frames sent back to back with no idle cycles, including one-byte frames, push the verdict queue and the data queue to their deepest point. A frame of exactly six bytes puts the decision byte and the end byte on the same beat.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ADDR_BITS  = 48;
  localparam int OCTET      = 8;
  localparam int HDR_OCTETS = ADDR_BITS / OCTET;

  typedef logic [ADDR_BITS-1:0] mac_t;

  typedef struct packed {
    logic             sof;
    logic             eof;
    logic [OCTET-1:0] data;
  } beat_t;

  // All-ones destination.
  function automatic logic is_bcast(mac_t a);
    return &a;
  endfunction

  // Union of the accepted sources.
  function automatic logic dest_ok(mac_t d, mac_t uc, logic promisc, logic mc_hit);
    return promisc | is_bcast(d) | (d == uc) | mc_hit;
  endfunction
endpackage

// File: rtl/rxf_fifo.sv
module rxf_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int N_MC = 4,
  parameter int AW   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [ADDR_BITS:0]   wdata,
  output mac_t                 uc_addr,
  output logic                 promisc,
  output mac_t [N_MC-1:0]      mc_addr,
  output logic [N_MC-1:0]      mc_vld
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uc_addr <= '0;
      promisc <= 1'b0;
    end else if (we) begin
      if (addr == AW'(0)) uc_addr <= wdata[ADDR_BITS-1:0];
      if (addr == AW'(1)) promisc <= wdata[0];
    end
  end

  for (genvar i = 0; i < N_MC; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mc_addr[i] <= '0;
        mc_vld[i]  <= 1'b0;
      end else if (we && addr == AW'(i + 2)) begin
        mc_addr[i] <= wdata[ADDR_BITS-1:0];
        mc_vld[i]  <= wdata[ADDR_BITS];
      end
    end
  end
endmodule

// File: rtl/rxf_hdr_track.sv
module rxf_hdr_track
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [OCTET-1:0] in_data,
  output logic             take,
  output logic             decide_now,
  output logic             short_end,
  output mac_t             dest
);
  localparam int CW     = $clog2(HDR_OCTETS + 1);
  localparam int HIST_W = ADDR_BITS - OCTET;

  logic [CW-1:0]     idx, pos;
  logic              in_frame;
  logic [HIST_W-1:0] hist;

  assign take       = in_valid && (in_sof || in_frame);
  assign pos        = in_sof ? '0 : idx;
  assign decide_now = take && (pos == CW'(HDR_OCTETS - 1));
  assign short_end  = take && in_eof && (pos < CW'(HDR_OCTETS - 1));
  assign dest       = {hist, in_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      in_frame <= 1'b0;
      hist     <= '0;
    end else if (take) begin
      hist     <= {hist[HIST_W-OCTET-1:0], in_data};
      in_frame <= !in_eof;
      if (in_eof)                        idx <= '0;
      else if (pos != CW'(HDR_OCTETS))   idx <= pos + 1'b1;
      else                               idx <= pos;
    end
  end
endmodule

// File: rtl/rxf_mc_match.sv
module rxf_mc_match
  import rxf_pkg::*;
#(
  parameter int N_MC = 4
) (
  input  mac_t            dest,
  input  mac_t [N_MC-1:0] mc_addr,
  input  logic [N_MC-1:0] mc_vld,
  output logic            hit
);
  logic [N_MC-1:0] eq;

  for (genvar i = 0; i < N_MC; i++) begin : g_cmp
    assign eq[i] = mc_vld[i] && (mc_addr[i] == dest);
  end

  assign hit = |eq;
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int N_MC       = 4,
  parameter int DATA_DEPTH = 16,
  parameter int VERD_DEPTH = 8,
  localparam int CFG_AW    = $clog2(N_MC + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [ADDR_BITS:0]   cfg_wdata,
  input  logic                 in_valid,
  input  logic                 in_sof,
  input  logic                 in_eof,
  input  logic [OCTET-1:0]     in_data,
  output logic                 out_valid,
  output logic                 out_sof,
  output logic                 out_eof,
  output logic [OCTET-1:0]     out_data,
  output logic                 dec_valid,
  output logic                 dec_accept
);
  localparam int BEAT_W = $bits(beat_t);

  mac_t            uc_addr, dest;
  logic            promisc;
  mac_t [N_MC-1:0] mc_addr;
  logic [N_MC-1:0] mc_vld;

  // Named internal events, observed by the bound checker.
  logic  take, decide_now, short_end, mc_hit;
  logic  verdict_push, verdict_val;
  logic  data_empty, data_full, verd_empty, verd_full;
  logic  head_go, verd_head;
  beat_t in_beat, head_beat;

  rxf_cfg_regs #(.N_MC(N_MC), .AW(CFG_AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .uc_addr(uc_addr), .promisc(promisc), .mc_addr(mc_addr), .mc_vld(mc_vld)
  );

  rxf_hdr_track u_hdr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .take(take),
    .decide_now(decide_now), .short_end(short_end), .dest(dest)
  );

  rxf_mc_match #(.N_MC(N_MC)) u_mc (
    .dest(dest), .mc_addr(mc_addr), .mc_vld(mc_vld), .hit(mc_hit)
  );

  assign verdict_push = decide_now || short_end;
  assign verdict_val  = decide_now && dest_ok(dest, uc_addr, promisc, mc_hit);

  assign in_beat = '{sof: in_sof, eof: in_eof, data: in_data};

  rxf_fifo #(.W(BEAT_W), .DEPTH(DATA_DEPTH)) u_data_q (
    .clk(clk), .rst_n(rst_n), .push(take), .din(in_beat),
    .pop(head_go), .dout(head_beat), .empty(data_empty), .full(data_full)
  );

  rxf_fifo #(.W(1), .DEPTH(VERD_DEPTH)) u_verd_q (
    .clk(clk), .rst_n(rst_n), .push(verdict_push), .din(verdict_val),
    .pop(head_go && head_beat.eof), .dout(verd_head),
    .empty(verd_empty), .full(verd_full)
  );

  // Head byte leaves once its frame's verdict is queued.
  assign head_go   = !data_empty && !verd_empty;
  assign out_valid = head_go && verd_head;
  assign out_sof   = head_beat.sof;
  assign out_eof   = head_beat.eof;
  assign out_data  = head_beat.data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= verdict_push;
      dec_accept <= verdict_val;
    end
  end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
  import rxf_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic decide_now,
  input logic short_end,
  input logic promisc,
  input mac_t dest,
  input logic dec_valid,
  input logic dec_accept,
  input logic take,
  input logic data_full,
  input logic verdict_push,
  input logic verd_full
);
  assert_decide_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    decide_now |=> dec_valid);

  assert_bcast_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_now && (&dest)) |=> (dec_valid && dec_accept));

  assert_promisc_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_now && promisc) |=> (dec_valid && dec_accept));

  assert_short_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    short_end |=> (dec_valid && !dec_accept));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && data_full));

  assert_verdict_room_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(verdict_push && verd_full));
endmodule

bind rx_dest_filter rxf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .decide_now(decide_now), .short_end(short_end),
  .promisc(promisc), .dest(dest), .dec_valid(dec_valid), .dec_accept(dec_accept),
  .take(take), .data_full(data_full), .verdict_push(verdict_push),
  .verd_full(verd_full)
);

// File: tb/rx_dest_filter_tb.sv
module rx_dest_filter_tb;
  localparam int N_MC = 3;
  localparam int AW   = $clog2(N_MC + 2);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [48:0] cfg_wdata = '0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = '0;
  logic        out_valid, out_sof, out_eof, dec_valid, dec_accept;
  logic [7:0]  out_data;

  always #2 clk = ~clk;

  rx_dest_filter #(.N_MC(N_MC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .out_valid(out_valid),
    .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  int errors = 0;
  int checks = 0;

  // Behavioural model state.
  logic [47:0] m_uc = '0;
  logic        m_prom = 1'b0;
  logic [47:0] m_mc [N_MC];
  logic        m_mcv [N_MC];

  typedef struct { logic [7:0] d; logic s; logic e; string tag; } exp_beat_t;
  exp_beat_t exp_q[$];

  logic  drv_dec = 1'b0, drv_acc = 1'b0, q_dec = 1'b0, q_acc = 1'b0;
  string drv_tag = "R7", q_tag = "R7", idle_tag = "R6";

  always @(posedge clk) begin
    q_dec <= drv_dec;
    q_acc <= drv_acc;
    q_tag <= drv_tag;
  end

  task automatic fail(string r, string what, logic [63:0] act, logic [63:0] exp);
    errors++;
    $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
  endtask

  // Reference comparison on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (dec_valid !== q_dec)
        fail(q_dec ? q_tag : "R7", "dec_valid", dec_valid, q_dec);
      else if (q_dec && dec_accept !== q_acc)
        fail(q_tag, "dec_accept", dec_accept, q_acc);
      if (out_valid) begin
        checks++;
        if (exp_q.size() == 0) fail(idle_tag, "unexpected beat", out_data, 0);
        else begin
          exp_beat_t e;
          e = exp_q.pop_front();
          if ({out_sof, out_eof, out_data} !== {e.s, e.e, e.d})
            fail(e.tag, "beat sof/eof/data", {out_sof, out_eof, out_data}, {e.s, e.e, e.d});
        end
      end
    end
  end

  function automatic logic model_accept(logic [47:0] d, int len);
    logic hit;
    hit = m_prom || (d == m_uc) || (&d);
    for (int i = 0; i < N_MC; i++) if (m_mcv[i] && m_mc[i] == d) hit = 1'b1;
    return (len >= 6) && hit;
  endfunction

  task automatic cfg_write(int a, logic [48:0] wd);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = wd;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (a == 0) m_uc = wd[47:0];
    else if (a == 1) m_prom = wd[0];
    else if (a >= 2 && a < N_MC + 2) begin
      m_mc[a-2] = wd[47:0];
      m_mcv[a-2] = wd[48];
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; drv_dec = 1'b0;
    end
  endtask

  task automatic send(logic [47:0] d, int len, string tag, int gap);
    logic acc;
    logic [7:0] b;
    acc = model_accept(d, len);
    for (int i = 0; i < len; i++) begin
      b = (i < 6) ? d[47 - 8*i -: 8] : 8'(i * 7 + len);
      if (acc) exp_q.push_back('{d: b, s: (i == 0), e: (i == len - 1), tag: tag});
    end
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == len - 1);
      in_data = (i < 6) ? d[47 - 8*i -: 8] : 8'(i * 7 + len);
      drv_dec = (i == 5) || (len < 6 && i == len - 1);
      drv_acc = acc;
      drv_tag = tag;
    end
    idle(gap);
  endtask

  localparam logic [47:0] UC  = 48'h02_11_22_33_44_55;
  localparam logic [47:0] BC  = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] MCA = 48'h01_00_5E_00_00_07;
  localparam logic [47:0] OTH = 48'h02_AA_BB_CC_DD_EE;

  initial begin
    for (int i = 0; i < N_MC; i++) begin m_mc[i] = '0; m_mcv[i] = 1'b0; end
    repeat (4) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || dec_valid !== 1'b0)
        fail("R1", "outputs in reset", {out_valid, dec_valid}, 0);
    end
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || dec_valid !== 1'b0)
        fail("R1", "outputs after reset", {out_valid, dec_valid}, 0);
    end

    cfg_write(0, {1'b0, UC});
    send(UC, 10, "R2", 3);
    send(BC, 8, "R3", 3);
    send(OTH, 9, "R6", 3);
    send(MCA, 7, "R5", 2);
    send(UC, 6, "R5", 2);
    cfg_write(2, {1'b1, MCA});
    send(MCA, 7, "R4", 2);
    cfg_write(2, {1'b0, MCA});
    cfg_write(4, {1'b0, OTH});
    send(MCA, 7, "R4", 2);
    send(OTH, 8, "R4", 2);
    cfg_write(6, {1'b1, OTH});
    send(OTH, 8, "R11", 2);
    cfg_write(1, 49'd1);
    send(OTH, 7, "R8", 2);
    send(48'h12_34_56_78_9A_BC, 6, "R7", 2);
    send(OTH, 3, "R9", 2);
    send(UC, 1, "R9", 2);
    cfg_write(1, 49'd0);
    send(OTH, 7, "R11", 2);

    // Stray bytes outside any frame.
    idle_tag = "R12";
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_sof = 1'b0; in_eof = (i == 3); in_data = 8'(i);
      drv_dec = 1'b0;
    end
    idle(6);
    idle_tag = "R6";

    // Back-to-back frames.
    send(UC, 7, "R10", 0);
    send(BC, 1, "R9", 0);
    send(BC, 6, "R10", 0);
    send(OTH, 9, "R6", 0);
    send(UC, 12, "R10", 0);
    send(UC, 2, "R9", 0);
    send(BC, 8, "R10", 20);

    checks++;
    if (exp_q.size() != 0) fail("R10", "beats never emitted", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fail("WATCHDOG", "run did not finish", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule